// File: doc/BRIEF.md
# Transmit Descriptor Ring Reader

This block serves the send path of a packet interface whose descriptors sit in host memory. When it is polled, it reads the descriptor at its current pointer. If the descriptor belongs to the hardware, it gathers that packet's bytes from one buffer or from a chain of continued buffers into local storage. Once the chain is complete, it sends the packet out as a byte stream marked with start and end flags. Last, it hands the first descriptor back to software and pulses an interrupt.

All descriptor and buffer traffic uses one 32-bit memory master port. That port carries one request at a time, and the request is held until it is acknowledged. Software chooses the ring start address and can load the current pointer while the block is idle. Line framing and check sequences belong to a later stage.

Top module: `txdesc_ring_reader`

## Requirements
- R1: After reset, `mem_req`, `tx_valid` and `irq` are low and `cur_ptr` is zero.
- R2: A `ptr_load` pulse in idle sets the pointer to `ptr_value`. If it coincides with an accepted poll, the scan starts at the loaded value. A `ptr_load` during a scan is ignored.
- R3: A poll causes no memory traffic when `ring_base` is zero or `link_up` is low. A poll that arrives during a scan is ignored.
- R4: A descriptor has a control word at its address and a buffer-address word at address+4. The control word holds bit 31 for hardware ownership, bit 30 for wrap, bit 27 for continuation, and the byte count in bits 12:0. If the first descriptor has bit 31 clear, the only access is that one control-word read, and the pointer does not change.
- R5: Buffer words are read from the buffer address with bits 1:0 cleared, at consecutive +4 addresses. A descriptor with a count of n bytes takes ceil(n/4) word reads.
- R6: Bytes are taken from each buffer word with bits 31:24 first. Only the counted bytes are appended to the packet.
- R7: A descriptor with a zero count issues no buffer read.
- R8: Every descriptor after the first has its control word overwritten with zero once its buffer reads are finished.
- R9: After each descriptor, the pointer becomes `ring_base` if the wrap bit is set and pointer+8 otherwise. Gathering goes on to the next descriptor while the continuation bit is set.
- R10: If a continued descriptor has bit 31 clear, the scan stops. No bytes are sent, the first descriptor is not written, no interrupt is raised, and the pointer is left at the refused descriptor.
- R11: After a complete gather with a nonzero total, the bytes leave in order. `tx_sop` marks the first byte and `tx_eop` the last. `tx_data` holds while `tx_ready` is low. With a zero total, nothing is sent.
- R12: After the stream ends, or straight away when the total is zero, the first control word is written back with bit 31 cleared and all other bits kept. `irq` pulses for one cycle in the cycle after that write is acknowledged.
- R13: A packet holds at most MAX_BYTES bytes (8192 by default). Bytes gathered beyond that limit are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ring_base | input | 32 | Address of the first descriptor of the ring |
| ptr_load | input | 1 | Load `ptr_value` into the current pointer |
| ptr_value | input | 32 | Pointer value to load |
| link_up | input | 1 | Downstream link is present |
| poll | input | 1 | Request one ring scan |
| mem_req | output | 1 | Memory request, held until acknowledged |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request completes at this edge |
| mem_rdata | input | 32 | Read data, valid with `mem_ack` |
| tx_valid | output | 1 | Stream byte valid |
| tx_data | output | 8 | Stream byte |
| tx_sop | output | 1 | First byte of a packet |
| tx_eop | output | 1 | Last byte of a packet |
| tx_ready | input | 1 | Downstream accepts the byte |
| irq | output | 1 | Completion pulse |
| cur_ptr | output | 32 | Current descriptor pointer |

## Verification
A pointer load and a poll can land in the same idle cycle. The bench drives both together with a pointer value that differs from the stored one. It then judges the result by the address of the first control-word read and by the final pointer. A second collision is the last stream byte against the release write. Every release acknowledgement is checked against an empty expected-byte queue, so a write that arrives early is caught whatever the `tx_ready` pattern is.

// File: rtl/txr_pkg.sv
package txr_pkg;
    localparam int OWN_BIT  = 31;
    localparam int WRAP_BIT = 30;
    localparam int CONT_BIT = 27;
    localparam int LEN_W    = 13;
    localparam logic [31:0] DESC_STEP = 32'd8;
    localparam logic [31:0] PTR_WORD  = 32'd4;

    typedef struct packed {
        logic             wrap;
        logic             cont;
        logic [LEN_W-1:0] len;
    } desc_ctl_t;

    typedef enum logic [3:0] {
        W_IDLE, W_RD_CTL, W_RD_PTR, W_RD_BUF, W_APPEND,
        W_CLR, W_STEP, W_EMIT, W_REL
    } walk_st_t;

    function automatic desc_ctl_t decode_ctl(input logic [31:0] w);
        desc_ctl_t c;
        c.wrap = w[WRAP_BIT];
        c.cont = w[CONT_BIT];
        c.len  = w[LEN_W-1:0];
        return c;
    endfunction

    function automatic logic [7:0] pick_byte(input logic [31:0] w, input logic [1:0] lane);
        case (lane)
            2'd0:    return w[31:24];
            2'd1:    return w[23:16];
            2'd2:    return w[15:8];
            default: return w[7:0];
        endcase
    endfunction
endpackage

// File: rtl/txr_byte_store.sv
module txr_byte_store #(
    parameter int DEPTH_BYTES = 8192,
    parameter int IDX_W       = 13
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [7:0]       wr_byte,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [7:0]       rd_byte
);
    localparam int WORDS = DEPTH_BYTES / 4;

    logic [3:0][7:0] store_q [WORDS];

    always_ff @(posedge clk) begin
        if (wr_en) store_q[wr_idx[IDX_W-1:2]][wr_idx[1:0]] <= wr_byte;
    end

    assign rd_byte = store_q[rd_idx[IDX_W-1:2]][rd_idx[1:0]];
endmodule

// File: rtl/txr_emitter.sv
module txr_emitter #(
    parameter int IDX_W = 13,
    parameter int CNT_W = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] len,
    output logic [IDX_W-1:0] rd_idx,
    input  logic [7:0]       rd_byte,
    output logic             tx_valid,
    output logic [7:0]       tx_data,
    output logic             tx_sop,
    output logic             tx_eop,
    input  logic             tx_ready,
    output logic             done
);
    logic             busy;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] len_q;
    logic             last;
    logic             fire;

    assign last     = (CNT_W'(idx) == len_q - CNT_W'(1));
    assign fire     = busy & tx_ready;
    assign rd_idx   = idx;
    assign tx_valid = busy;
    assign tx_data  = rd_byte;
    assign tx_sop   = busy & (idx == '0);
    assign tx_eop   = busy & last;
    assign done     = fire & last;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy  <= 1'b0;
            idx   <= '0;
            len_q <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            idx   <= '0;
            len_q <= len;
        end else if (fire) begin
            if (last) busy <= 1'b0;
            else      idx  <= idx + IDX_W'(1);
        end
    end

    AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (rst)
        (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data) && $stable(tx_eop))); // R11
    AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
        start |-> !tx_valid); // R11
endmodule

// File: rtl/txr_walker.sv
module txr_walker
    import txr_pkg::*;
#(
    parameter int MAX_BYTES = 8192,
    parameter int IDX_W     = 13,
    parameter int CNT_W     = 14
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [31:0]      ring_base,
    input  logic             ptr_load,
    input  logic [31:0]      ptr_value,
    input  logic             link_up,
    input  logic             poll,
    output logic             mem_req,
    output logic             mem_we,
    output logic [31:0]      mem_addr,
    output logic [31:0]      mem_wdata,
    input  logic             mem_ack,
    input  logic [31:0]      mem_rdata,
    output logic             app_en,
    output logic [IDX_W-1:0] app_idx,
    output logic [7:0]       app_byte,
    output logic             emit_start,
    output logic [CNT_W-1:0] emit_len,
    input  logic             emit_done,
    output logic             irq,
    output logic [31:0]      cur_ptr
);
    walk_st_t         st;
    desc_ctl_t        ctl, rd_ctl;
    logic [31:0]      ptr, first_ptr, first_w0, buf_addr, word;
    logic [LEN_W-1:0] rem;
    logic [1:0]       lane;
    logic [CNT_W-1:0] total;
    logic             is_first;
    logic             go;
    logic             room;

    assign rd_ctl = decode_ctl(mem_rdata);
    assign go     = poll && link_up && (ring_base != '0);
    assign room   = total < CNT_W'(MAX_BYTES);

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = ptr;
        mem_wdata = '0;
        case (st)
            W_RD_CTL: mem_req = 1'b1;
            W_RD_PTR: begin mem_req = 1'b1; mem_addr = ptr + PTR_WORD; end
            W_RD_BUF: begin mem_req = 1'b1; mem_addr = buf_addr; end
            W_CLR:    begin mem_req = 1'b1; mem_we = 1'b1; end
            W_REL: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = first_ptr;
                mem_wdata = first_w0 & ~(32'd1 << OWN_BIT);
            end
            default: ;
        endcase
    end

    assign app_en   = (st == W_APPEND) && room;
    assign app_idx  = total[IDX_W-1:0];
    assign app_byte = pick_byte(word, lane);
    assign emit_len = total;
    assign cur_ptr  = ptr;

    always_ff @(posedge clk) begin
        if (rst) begin
            st         <= W_IDLE;
            ptr        <= '0;
            first_ptr  <= '0;
            first_w0   <= '0;
            ctl        <= '0;
            buf_addr   <= '0;
            word       <= '0;
            rem        <= '0;
            lane       <= '0;
            total      <= '0;
            is_first   <= 1'b0;
            irq        <= 1'b0;
            emit_start <= 1'b0;
        end else begin
            irq        <= 1'b0;
            emit_start <= 1'b0;
            case (st)
                W_IDLE: begin
                    if (ptr_load) ptr <= ptr_value;
                    if (go) begin
                        first_ptr <= ptr_load ? ptr_value : ptr;
                        total     <= '0;
                        is_first  <= 1'b1;
                        st        <= W_RD_CTL;
                    end
                end
                W_RD_CTL: if (mem_ack) begin
                    ctl <= rd_ctl;
                    if (is_first) first_w0 <= mem_rdata;
                    st <= mem_rdata[OWN_BIT] ? W_RD_PTR : W_IDLE;
                end
                W_RD_PTR: if (mem_ack) begin
                    buf_addr <= {mem_rdata[31:2], 2'b00};
                    rem      <= ctl.len;
                    if (ctl.len == '0) st <= is_first ? W_STEP : W_CLR;
                    else               st <= W_RD_BUF;
                end
                W_RD_BUF: if (mem_ack) begin
                    word <= mem_rdata;
                    lane <= 2'd0;
                    st   <= W_APPEND;
                end
                W_APPEND: begin
                    if (room) total <= total + CNT_W'(1);
                    rem  <= rem - LEN_W'(1);
                    lane <= lane + 2'd1;
                    if (rem == LEN_W'(1)) begin
                        st <= is_first ? W_STEP : W_CLR;
                    end else if (lane == 2'd3) begin
                        buf_addr <= buf_addr + 32'd4;
                        st       <= W_RD_BUF;
                    end
                end
                W_CLR: if (mem_ack) st <= W_STEP;
                W_STEP: begin
                    ptr      <= ctl.wrap ? ring_base : ptr + DESC_STEP;
                    is_first <= 1'b0;
                    if (ctl.cont) begin
                        st <= W_RD_CTL;
                    end else if (total != '0) begin
                        emit_start <= 1'b1;
                        st         <= W_EMIT;
                    end else begin
                        st <= W_REL;
                    end
                end
                W_EMIT: if (emit_done) st <= W_REL;
                W_REL: if (mem_ack) begin
                    irq <= 1'b1;
                    st  <= W_IDLE;
                end
                default: st <= W_IDLE;
            endcase
        end
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        total <= CNT_W'(MAX_BYTES)); // R13
    AST_REQ_STEADY: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we))); // R5
    AST_IRQ_FOLLOWS_WRITE: assert property (@(posedge clk) disable iff (rst)
        irq |-> $past(mem_req && mem_we && mem_ack)); // R12
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq); // R12
    AST_NO_EMPTY_FETCH: assert property (@(posedge clk) disable iff (rst)
        (st == W_RD_BUF) |-> (rem != '0)); // R7
endmodule

// File: rtl/txdesc_ring_reader.sv
module txdesc_ring_reader #(
    parameter int MAX_BYTES = 8192
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] ring_base,
    input  logic        ptr_load,
    input  logic [31:0] ptr_value,
    input  logic        link_up,
    input  logic        poll,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [31:0] mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        tx_sop,
    output logic        tx_eop,
    input  logic        tx_ready,
    output logic        irq,
    output logic [31:0] cur_ptr
);
    localparam int IDX_W = $clog2(MAX_BYTES);
    localparam int CNT_W = $clog2(MAX_BYTES + 1);

    logic             app_en;
    logic [IDX_W-1:0] app_idx, rd_idx;
    logic [7:0]       app_byte, rd_byte;
    logic             emit_start, emit_done;
    logic [CNT_W-1:0] emit_len;

    txr_walker #(.MAX_BYTES(MAX_BYTES), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_walker (
        .clk(clk), .rst(rst), .ring_base(ring_base), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .link_up(link_up), .poll(poll),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .app_en(app_en), .app_idx(app_idx), .app_byte(app_byte),
        .emit_start(emit_start), .emit_len(emit_len), .emit_done(emit_done),
        .irq(irq), .cur_ptr(cur_ptr)
    );

    txr_byte_store #(.DEPTH_BYTES(MAX_BYTES), .IDX_W(IDX_W)) u_store (
        .clk(clk), .wr_en(app_en), .wr_idx(app_idx), .wr_byte(app_byte),
        .rd_idx(rd_idx), .rd_byte(rd_byte)
    );

    txr_emitter #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_emitter (
        .clk(clk), .rst(rst), .start(emit_start), .len(emit_len),
        .rd_idx(rd_idx), .rd_byte(rd_byte), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_sop(tx_sop), .tx_eop(tx_eop),
        .tx_ready(tx_ready), .done(emit_done)
    );

    AST_RELEASE_AFTER_STREAM: assert property (@(posedge clk) disable iff (rst)
        tx_valid |-> !mem_req); // R12
endmodule

// File: tb/txdesc_ring_reader_bench.sv
module txdesc_ring_reader_bench;
    localparam int MAXB = 8192;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst = 1'b1;
    logic [31:0] ring_base = '0, ptr_value = '0, mem_rdata = '0;
    logic        ptr_load = 1'b0, link_up = 1'b0, poll = 1'b0;
    logic        mem_ack = 1'b0, tx_ready = 1'b0;
    wire         mem_req, mem_we, tx_valid, tx_sop, tx_eop, irq;
    wire  [31:0] mem_addr, mem_wdata, cur_ptr;
    wire  [7:0]  tx_data;

    txdesc_ring_reader #(.MAX_BYTES(MAXB)) u_txdesc_ring_reader (
        .clk(clk), .rst(rst), .ring_base(ring_base), .ptr_load(ptr_load),
        .ptr_value(ptr_value), .link_up(link_up), .poll(poll),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_sop(tx_sop),
        .tx_eop(tx_eop), .tx_ready(tx_ready), .irq(irq), .cur_ptr(cur_ptr)
    );

    typedef struct {
        bit        we;
        bit [31:0] addr;
        bit [31:0] data;
        bit        rel;
    } op_t;

    int          n_chk = 0, n_bad = 0;
    bit   [31:0] mem [int unsigned];
    op_t         exp_ops [$];
    bit   [9:0]  exp_bytes [$];
    int          irq_due = 0;
    bit   [31:0] exp_ptr = '0;
    string       tag = "R1";

    function automatic bit [31:0] ctlw(bit own, bit wrap, bit cont, int len);
        return {own, wrap, 2'b00, cont, 14'd0, 13'(len)};
    endfunction

    task automatic chk(bit ok, string req, string what, bit [31:0] act, bit [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic push_op(bit we, bit [31:0] a, bit [31:0] d, bit rel);
        op_t o;
        o.we = we; o.addr = a; o.data = d; o.rel = rel;
        exp_ops.push_back(o);
    endtask

    // Behavioural reference: walks a private copy of memory and queues every
    // expected memory operation and stream byte in order.
    task automatic model(bit [31:0] start);
        bit [31:0] m [int unsigned];
        bit [31:0] p, w0, fw0, w1, ba, wd;
        bit [7:0]  bq [$];
        int        tot;
        bit        firstd;
        m = mem;
        p = start; tot = 0; firstd = 1; wd = '0;
        exp_ptr = start;
        if (ring_base == '0 || !link_up) return;
        w0 = m.exists(p) ? m[p] : '0;
        push_op(0, p, '0, 0);
        if (!w0[31]) return;
        fw0 = w0;
        forever begin
            push_op(0, p + 4, '0, 0);
            w1 = m.exists(p + 4) ? m[p + 4] : '0;
            ba = {w1[31:2], 2'b00};
            for (int i = 0; i < int'(w0[12:0]); i++) begin
                if (i % 4 == 0) begin
                    push_op(0, ba + i, '0, 0);
                    wd = m.exists(ba + i) ? m[ba + i] : '0;
                end
                if (tot < MAXB) bq.push_back(8'(wd >> (24 - 8 * (i % 4))));
                tot++;
            end
            if (!firstd) begin
                push_op(1, p, '0, 0);
                m[p] = '0;
            end
            p = w0[30] ? ring_base : p + 8;
            if (!w0[27]) break;
            firstd = 0;
            w0 = m.exists(p) ? m[p] : '0;
            push_op(0, p, '0, 0);
            if (!w0[31]) begin
                exp_ptr = p;
                return;
            end
        end
        for (int i = 0; i < bq.size(); i++)
            exp_bytes.push_back({i == 0, i == bq.size() - 1, bq[i]});
        push_op(1, start, fw0 & 32'h7fff_ffff, 1);
        exp_ptr = p;
    endtask

    // Memory responder and per-clock comparison against the reference queues.
    always @(negedge clk) begin
        op_t o;
        mem_ack  = 1'b0;
        tx_ready = ($urandom % 4) != 0;
        if (!rst && mem_req && (($urandom % 3) != 0)) begin
            mem_ack = 1'b1;
            if (exp_ops.size() == 0) begin
                chk(0, tag, "unexpected memory access", mem_addr, '0);
            end else begin
                o = exp_ops.pop_front();
                chk(mem_addr == o.addr, tag, "memory address", mem_addr, o.addr);
                chk(mem_we == o.we, tag, "memory direction", 32'(mem_we), 32'(o.we));
                if (o.we) chk(mem_wdata == o.data, tag, "write data", mem_wdata, o.data);
                if (o.rel) begin
                    chk(exp_bytes.size() == 0, "R12", "release before stream end",
                        exp_bytes.size(), 0);
                    irq_due++;
                end
            end
            if (mem_we) mem[mem_addr] = mem_wdata;
            else        mem_rdata = mem.exists(mem_addr) ? mem[mem_addr] : '0;
        end
        if (!rst && tx_valid && tx_ready) begin
            if (exp_bytes.size() == 0) begin
                chk(0, "R11", "unexpected stream byte", {tx_sop, tx_eop, tx_data}, '0);
            end else begin
                bit [9:0] e;
                e = exp_bytes.pop_front();
                chk({tx_sop, tx_eop, tx_data} == e, "R11", "stream {sop,eop,byte}",
                    {tx_sop, tx_eop, tx_data}, e);
            end
        end
        if (!rst && irq) begin
            chk(irq_due > 0, "R12", "interrupt without release", 1, 0);
            if (irq_due > 0) irq_due--;
        end
    end

    task automatic settle();
        repeat (30) @(negedge clk);
        while (exp_ops.size() != 0 || exp_bytes.size() != 0 || irq_due != 0) @(negedge clk);
        repeat (12) @(negedge clk);
    endtask

    // mode 0: load then poll; 1: load with poll in one cycle; 2: disturb mid-scan
    task automatic scan(string t, bit [31:0] base, bit [31:0] start, bit lk, int mode);
        @(negedge clk);
        tag = t; ring_base = base; link_up = lk;
        if (mode != 1) begin
            ptr_load = 1'b1; ptr_value = start;
            @(negedge clk);
            ptr_load = 1'b0; ptr_value = 32'h0bad_0000;
        end
        model(start);
        @(negedge clk);
        poll = 1'b1;
        if (mode == 1) begin ptr_load = 1'b1; ptr_value = start; end
        @(negedge clk);
        poll = 1'b0; ptr_load = 1'b0;
        if (mode == 2) begin
            repeat (3) @(negedge clk);
            ptr_load = 1'b1; ptr_value = 32'hdead_0000; poll = 1'b1;
            @(negedge clk);
            ptr_load = 1'b0; poll = 1'b0;
        end
        settle();
        chk(cur_ptr == exp_ptr, t, "final pointer", cur_ptr, exp_ptr);
        chk(exp_ops.size() == 0, t, "memory ops left", exp_ops.size(), 0);
        chk(exp_bytes.size() == 0, "R11", "stream bytes left", exp_bytes.size(), 0);
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : stimulus
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk(mem_req == 1'b0, "R1", "reset mem_req", 32'(mem_req), 0);
        chk(tx_valid == 1'b0, "R1", "reset tx_valid", 32'(tx_valid), 0);
        chk(irq == 1'b0, "R1", "reset irq", 32'(irq), 0);
        chk(cur_ptr == '0, "R1", "reset pointer", cur_ptr, 0);

        mem[32'h1000] = ctlw(1, 0, 0, 4); mem[32'h1004] = 32'h8000;
        scan("R3", 32'h0, 32'h1000, 1, 0);            // zero ring base
        scan("R3", 32'h1000, 32'h1000, 0, 0);         // link absent

        mem[32'h1000] = ctlw(0, 0, 0, 5);             // not owned: R4
        scan("R4", 32'h1000, 32'h1000, 1, 0);

        // single descriptor, odd count, unaligned buffer, spare bit 29 kept
        mem[32'h1000] = ctlw(1, 0, 0, 7) | 32'h2000_0000;
        mem[32'h1004] = 32'h8002;
        mem[32'h8000] = 32'h1122_3344; mem[32'h8004] = 32'h5566_7788;
        scan("R5", 32'h1000, 32'h1000, 1, 0);         // checks R6 and R12 too

        // chain with a zero-count middle descriptor: R7, R8
        mem[32'h1010] = ctlw(1, 0, 1, 3); mem[32'h1014] = 32'h8100;
        mem[32'h1018] = ctlw(1, 0, 1, 0); mem[32'h101c] = 32'h8180;
        mem[32'h1020] = ctlw(1, 0, 0, 6); mem[32'h1024] = 32'h8200;
        mem[32'h8100] = 32'ha1a2_a3a4;
        mem[32'h8200] = 32'hb1b2_b3b4; mem[32'h8204] = 32'hb5b6_b7b8;
        scan("R8", 32'h1000, 32'h1010, 1, 0);

        // wrap from the ring end back to the base: R9
        mem[32'h1018] = ctlw(1, 1, 1, 2); mem[32'h101c] = 32'h8300;
        mem[32'h1000] = ctlw(1, 0, 0, 4); mem[32'h1004] = 32'h8400;
        mem[32'h8300] = 32'hc1c2_c3c4; mem[32'h8400] = 32'hd1d2_d3d4;
        scan("R9", 32'h1000, 32'h1018, 1, 0);

        // continued descriptor not owned: R10
        mem[32'h1030] = ctlw(1, 0, 1, 4); mem[32'h1034] = 32'h8500;
        mem[32'h1038] = ctlw(1, 0, 1, 2); mem[32'h103c] = 32'h8600;
        mem[32'h1040] = ctlw(0, 0, 0, 3); mem[32'h1044] = 32'h8700;
        mem[32'h8500] = 32'he1e2_e3e4; mem[32'h8600] = 32'hf1f2_f3f4;
        scan("R10", 32'h1000, 32'h1030, 1, 0);

        // zero total: release and interrupt, no stream (R11, R12)
        mem[32'h1050] = ctlw(1, 0, 0, 0); mem[32'h1054] = 32'h8800;
        scan("R12", 32'h1000, 32'h1050, 1, 0);

        // pointer load and poll in the same cycle: R2
        mem[32'h1060] = ctlw(1, 0, 0, 1); mem[32'h1064] = 32'h8900;
        mem[32'h8900] = 32'h5a00_0000;
        scan("R2", 32'h1000, 32'h1060, 1, 1);

        // load and poll during a scan are ignored: R2 and R3
        mem[32'h1070] = ctlw(1, 0, 1, 20); mem[32'h1074] = 32'h8a00;
        mem[32'h1078] = ctlw(1, 0, 0, 20); mem[32'h107c] = 32'h8b00;
        for (int k = 0; k < 5; k++) begin
            mem[32'h8a00 + 4 * k] = 32'h0101_0101 * (k + 3);
            mem[32'h8b00 + 4 * k] = 32'h1020_3040 + k;
        end
        scan("R2", 32'h1000, 32'h1070, 1, 2);

        // gather beyond the packet limit: R13
        mem[32'h1080] = ctlw(1, 0, 1, 8191); mem[32'h1084] = 32'h1_0000;
        mem[32'h1088] = ctlw(1, 0, 0, 100);  mem[32'h108c] = 32'h2_0000;
        for (int k = 0; k < 2048; k++) mem[32'h1_0000 + 4 * k] = 32'h9e37_79b1 * (k + 1);
        for (int k = 0; k < 25; k++)   mem[32'h2_0000 + 4 * k] = 32'h7f4a_7c15 ^ k;
        scan("R13", 32'h1000, 32'h1080, 1, 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule